// File: doc/BRIEF.md
# Memory-Mapped Serial Port

This block is a small serial port that sits on a simple word-wide register bus. Software sees four registers: a control word with enable bits, a status word with flag bits, a data word for sending and receiving, and a bit-time divider. A write to the data word sends one 8-bit character on the serial output. It uses one start bit, eight data bits with the least significant bit first, and one stop bit. The receiver collects two characters in a row on the serial input. The first is a command byte and the second is a data byte. It presents them together as one 16-bit frame.

An external clock-enable input gates all serial activity. While it is low, both shifters hold their state, the receiver cannot deliver a frame, and the block ignores data writes meant for transmission. Reception is enabled in two ways: by the standard pair of bits (peripheral enable together with receive enable), or by an older single-bit enable kept for compatibility. The status word also repeats the receive-ready flag in bit 0, so older software can still use it.

Top module: `mmio_serial_port`

## Requirements
- R1: After reset, control reads 0x00000000, status reads 0x000000C0, data reads 0x00000000, the divider reads 0x00000000 and `txd` is high. Offsets: control 0x30, status 0x34, data 0x38, divider 0x3C. Status bits: 7 transmit-empty, 6 transmit-complete, 5 receive-full, 3 overrun, 1 framing error, 0 copy of receive-full.
- R2: The control register stores and reads back a full 32-bit word. The divider stores its low 16 bits and reads zero above them. One bit time is the divider value in clock cycles, and values below 8 act as 8.
- R3: A data write is accepted when all of these hold: clock-enable is high, control bit 13 (enable) is set, control bit 3 (transmit) is set, and transmit-empty is 1. An accepted write clears transmit-empty and transmit-complete. Transmit-empty sets again when the shifter takes the byte. Transmit-complete sets after the stop bit, provided no further byte is waiting. The line carries a 0 start bit, bits 7:0 least significant bit first, and a 1 stop bit.
- R4: A data write has no effect when clock-enable is low, when bit 13 or bit 3 is clear, or when transmit-empty is 0. In each case the line stays idle and the status flags stay unchanged.
- R5: When the second stop bit of a command-then-data character pair is sampled, status bits 5 and 0 set. A data read then returns the command byte in bits 15:8 and the data byte in bits 7:0, with bits 31:16 reading 0.
- R6: A data read clears status bits 5 and 0.
- R7: Reception is enabled when control bits 13 and 2 are both set, or when control bit 0 is set. With neither condition met, the input line is ignored.
- R8: While clock-enable is low, no frame is received and receive-full never rises.
- R9: If a frame completes while receive-full is still set, overrun (bit 3) sets and the earlier frame is kept.
- R10: If the stop bit of either character samples low, framing error (bit 1) sets. The frame is still delivered.
- R11: In a status write, a 0 in bit 6, 3 or 1 clears that flag. A 1 in those bits leaves the flag unchanged, and the receive and transmit-empty flags are not touched by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Peripheral clock-enable gate for serial activity |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while selected |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
Some properties are checked on every cycle: transmit-complete never stands without transmit-empty, an accepted data write drops both transmit flags, a data read drops the receive flag, and a gated clock-enable freezes the output line and keeps the receive flag from rising. On every overrun the held frame is checked to stay unchanged. Other behaviours can only be shown by the bench scenarios. These are the bit order and framing on the line, the packing of a received command:data pair, the legacy enable path, the setting of the framing error, and the write-zero clearing of the sticky flags.

// File: rtl/msp_pkg.sv
package msp_pkg;

    // register offsets (byte addresses)
    localparam logic [7:0] OFF_CTRL = 8'h30;
    localparam logic [7:0] OFF_STAT = 8'h34;
    localparam logic [7:0] OFF_DATA = 8'h38;
    localparam logic [7:0] OFF_BAUD = 8'h3C;

    // control bit positions
    localparam int CTL_UE  = 13;
    localparam int CTL_TE  = 3;
    localparam int CTL_RE  = 2;
    localparam int CTL_RXL = 0;

    // status bit positions
    localparam int ST_TXE  = 7;
    localparam int ST_TC   = 6;
    localparam int ST_RXNE = 5;
    localparam int ST_ORE  = 3;
    localparam int ST_FE   = 1;
    localparam int ST_RDY  = 0;

    localparam logic [31:0] STAT_RESET = 32'h0000_00C0;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP
    } rx_phase_e;

endpackage

// File: rtl/msp_tx.sv
module msp_tx #(
    parameter int CHAR_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  period,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    output logic              taken,
    output logic              done,
    output logic              txd
);
    localparam int IDX_W = $clog2(CHAR_W + 2);
    localparam logic [IDX_W-1:0] IDX_LAST_DATA = IDX_W'(CHAR_W);
    localparam logic [IDX_W-1:0] IDX_STOP      = IDX_W'(CHAR_W + 1);

    typedef struct packed {
        logic              busy;
        logic [DIV_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [CHAR_W-1:0] sh;
        logic              txd;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        taken = 1'b0;
        done  = 1'b0;
        if (run) begin
            if (!st_q.busy) begin
                if (load) begin
                    taken      = 1'b1;
                    st_d.busy  = 1'b1;
                    st_d.cnt   = '0;
                    st_d.idx   = '0;
                    st_d.sh    = load_data;
                    st_d.txd   = 1'b0;
                end
            end else if (st_q.cnt == period - 1'b1) begin
                st_d.cnt = '0;
                if (st_q.idx == IDX_STOP) begin
                    st_d.busy = 1'b0;
                    st_d.txd  = 1'b1;
                    done      = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    if (st_q.idx == IDX_LAST_DATA) begin
                        st_d.txd = 1'b1;
                    end else begin
                        st_d.txd = st_q.sh[0];
                        st_d.sh  = {1'b0, st_q.sh[CHAR_W-1:1]};
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0, idx: '0, sh: '0, txd: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign txd = st_q.txd;

endmodule

// File: rtl/msp_rx.sv
module msp_rx
    import msp_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                active,
    input  logic [DIV_W-1:0]    period,
    input  logic                rxd_pin,
    output logic                done,
    output logic [2*CHAR_W-1:0] frame,
    output logic                frame_bad
);
    localparam int IDX_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHAR_W - 1);

    typedef struct packed {
        logic [1:0]        sync;
        rx_phase_e         phase;
        logic [DIV_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [CHAR_W-1:0] sh;
        logic              second;
        logic [CHAR_W-1:0] cmd;
        logic              bad;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic             line;
    logic [DIV_W-1:0] half;

    assign line = st_q.sync[1];
    assign half = period >> 1;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], rxd_pin};
        done      = 1'b0;
        frame     = {st_q.cmd, st_q.sh};
        frame_bad = st_q.bad | ~line;
        if (!active) begin
            st_d.phase  = RX_IDLE;
            st_d.second = 1'b0;
            st_d.bad    = 1'b0;
            st_d.cnt    = '0;
        end else if (run) begin
            unique case (st_q.phase)
                RX_IDLE: begin
                    st_d.cnt = '0;
                    if (!line) st_d.phase = RX_START;
                end
                RX_START: begin
                    if (st_q.cnt == half - 1'b1) begin
                        st_d.cnt   = '0;
                        st_d.idx   = '0;
                        st_d.phase = line ? RX_IDLE : RX_BITS;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (st_q.cnt == period - 1'b1) begin
                        st_d.cnt = '0;
                        st_d.sh  = {line, st_q.sh[CHAR_W-1:1]};
                        if (st_q.idx == IDX_LAST) st_d.phase = RX_STOP;
                        else                      st_d.idx   = st_q.idx + 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (st_q.cnt == period - 1'b1) begin
                        st_d.cnt   = '0;
                        st_d.phase = RX_IDLE;
                        if (!st_q.second) begin
                            st_d.cmd    = st_q.sh;
                            st_d.second = 1'b1;
                            st_d.bad    = ~line;
                        end else begin
                            done        = 1'b1;
                            st_d.second = 1'b0;
                            st_d.bad    = 1'b0;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: st_d.phase = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync: 2'b11, phase: RX_IDLE, cnt: '0, idx: '0, sh: '0,
                      second: 1'b0, cmd: '0, bad: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mmio_serial_port.sv
module mmio_serial_port
    import msp_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DIV_W   = 16,
    parameter int MIN_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rxd,
    output logic              txd
);
    localparam int CHAR_W = 8;
    localparam int FRAME_W = 2 * CHAR_W;
    localparam logic [DIV_W-1:0] MIN_PERIOD = DIV_W'(MIN_BIT);

    typedef struct packed {
        logic [31:0]        ctrl;
        logic [DIV_W-1:0]   baud;
        logic               txe;
        logic               tc;
        logic               rxne;
        logic               ore;
        logic               fe;
        logic               hold_full;
        logic [CHAR_W-1:0]  hold;
        logic [FRAME_W-1:0] rxbuf;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic hit_ctrl, hit_stat, hit_data, hit_baud;
    logic wr_ctrl, wr_stat, wr_data, wr_baud, rd_data;
    logic tx_en, rx_active, dr_wr_ok;
    logic [DIV_W-1:0] bit_period;
    logic tx_taken, tx_done;
    logic rx_fire, rx_bad;
    logic [FRAME_W-1:0] rx_frame;
    logic [31:0] stat_word;

    // observation points for the bound checker
    logic [31:0]        ctrl_w;
    logic               flag_txe, flag_tc, flag_rxne, flag_ore;
    logic [FRAME_W-1:0] rx_hold;

    assign hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
    assign hit_stat = bus_addr == ADDR_W'(OFF_STAT);
    assign hit_data = bus_addr == ADDR_W'(OFF_DATA);
    assign hit_baud = bus_addr == ADDR_W'(OFF_BAUD);

    assign wr_ctrl = bus_sel &  bus_wr & hit_ctrl;
    assign wr_stat = bus_sel &  bus_wr & hit_stat;
    assign wr_data = bus_sel &  bus_wr & hit_data;
    assign wr_baud = bus_sel &  bus_wr & hit_baud;
    assign rd_data = bus_sel & ~bus_wr & hit_data;

    assign tx_en     = st_q.ctrl[CTL_UE] & st_q.ctrl[CTL_TE];
    assign rx_active = (st_q.ctrl[CTL_UE] & st_q.ctrl[CTL_RE]) | st_q.ctrl[CTL_RXL];
    assign dr_wr_ok  = wr_data & clk_en & tx_en & st_q.txe;

    assign bit_period = (st_q.baud < MIN_PERIOD) ? MIN_PERIOD : st_q.baud;

    msp_tx #(
        .CHAR_W (CHAR_W),
        .DIV_W  (DIV_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (clk_en),
        .period    (bit_period),
        .load      (st_q.hold_full),
        .load_data (st_q.hold),
        .taken     (tx_taken),
        .done      (tx_done),
        .txd       (txd)
    );

    msp_rx #(
        .CHAR_W (CHAR_W),
        .DIV_W  (DIV_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (clk_en),
        .active    (rx_active),
        .period    (bit_period),
        .rxd_pin   (rxd),
        .done      (rx_fire),
        .frame     (rx_frame),
        .frame_bad (rx_bad)
    );

    always_comb begin
        st_d = st_q;

        if (wr_ctrl) st_d.ctrl = bus_wdata;
        if (wr_baud) st_d.baud = bus_wdata[DIV_W-1:0];

        if (wr_stat) begin
            if (!bus_wdata[ST_TC])  st_d.tc  = 1'b0;
            if (!bus_wdata[ST_ORE]) st_d.ore = 1'b0;
            if (!bus_wdata[ST_FE])  st_d.fe  = 1'b0;
        end

        if (tx_taken) begin
            st_d.hold_full = 1'b0;
            st_d.txe       = 1'b1;
        end
        if (tx_done && !st_q.hold_full) st_d.tc = 1'b1;

        if (dr_wr_ok) begin
            st_d.hold      = bus_wdata[CHAR_W-1:0];
            st_d.hold_full = 1'b1;
            st_d.txe       = 1'b0;
            st_d.tc        = 1'b0;
        end

        if (rd_data) st_d.rxne = 1'b0;

        if (rx_fire) begin
            if (st_q.rxne && !rd_data) begin
                st_d.ore = 1'b1;
            end else begin
                st_d.rxbuf = rx_frame;
                st_d.rxne  = 1'b1;
            end
            if (rx_bad) st_d.fe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: '0, baud: '0, txe: 1'b1, tc: 1'b1, rxne: 1'b0,
                      ore: 1'b0, fe: 1'b0, hold_full: 1'b0, hold: '0, rxbuf: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_word          = '0;
        stat_word[ST_TXE]  = st_q.txe;
        stat_word[ST_TC]   = st_q.tc;
        stat_word[ST_RXNE] = st_q.rxne;
        stat_word[ST_ORE]  = st_q.ore;
        stat_word[ST_FE]   = st_q.fe;
        stat_word[ST_RDY]  = st_q.rxne;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_ctrl) bus_rdata = st_q.ctrl;
            if (hit_stat) bus_rdata = stat_word;
            if (hit_data) bus_rdata = 32'(st_q.rxbuf);
            if (hit_baud) bus_rdata = 32'(st_q.baud);
        end
    end

    assign ctrl_w    = st_q.ctrl;
    assign flag_txe  = st_q.txe;
    assign flag_tc   = st_q.tc;
    assign flag_rxne = st_q.rxne;
    assign flag_ore  = st_q.ore;
    assign rx_hold   = st_q.rxbuf;

endmodule

// File: rtl/mmio_serial_port_chk.sv
module mmio_serial_port_chk
    import msp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       ctrl,
    input logic              txe,
    input logic              tc,
    input logic              rxne,
    input logic              ore,
    input logic              rx_done,
    input logic [15:0]       rxbuf,
    input logic              txd
);
    logic data_hit, tx_accept, data_read;

    assign data_hit  = bus_sel && (bus_addr == ADDR_W'(OFF_DATA));
    assign tx_accept = data_hit && bus_wr && clk_en && ctrl[CTL_UE] && ctrl[CTL_TE] && txe;
    assign data_read = data_hit && !bus_wr;

    // R3
    tc_implies_txe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> txe);

    // R3
    tx_accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_accept |=> (!txe && !tc));

    // R6
    dr_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_read && !rx_done) |=> !rxne);

    // R8
    gated_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !$rose(rxne));

    // R4
    gated_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(txd));

    // R9
    overrun_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rxne && !data_read) |=> (ore && $stable(rxbuf)));

endmodule

bind mmio_serial_port mmio_serial_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ctrl     (ctrl_w),
    .txe      (flag_txe),
    .tc       (flag_tc),
    .rxne     (flag_rxne),
    .ore      (flag_ore),
    .rx_done  (rx_fire),
    .rxbuf    (rx_hold),
    .txd      (txd)
);

// File: tb/mmio_serial_port_tb.sv
module mmio_serial_port_tb;

    localparam int P = 16;
    localparam logic [7:0] A_CTRL = 8'h30;
    localparam logic [7:0] A_STAT = 8'h34;
    localparam logic [7:0] A_DATA = 8'h38;
    localparam logic [7:0] A_BAUD = 8'h3C;
    localparam logic [31:0] RX_MASK = 32'h0000_002B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mmio_serial_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rxd       (rxd),
        .txd       (txd)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic capture_byte(output logic [7:0] b, output logic stop);
        int n = 0;
        b = '0;
        stop = 1'b0;
        while (txd !== 1'b0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (P/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (P) @(negedge clk);
            b[i] = txd;
        end
        repeat (P) @(negedge clk);
        stop = txd;
    endtask

    task automatic line_idle(input string req, input int cycles);
        logic seen_low = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) seen_low = 1'b1;
        end
        chk(req, "txd idle", {31'b0, seen_low}, 32'h0);
    endtask

    task automatic send_char(input logic [7:0] b, input bit bad_stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (P) @(negedge clk);
        end
        if (bad_stop) begin
            rxd = 1'b0;
            repeat (12) @(negedge clk);
            rxd = 1'b1;
            repeat (P) @(negedge clk);
        end else begin
            rxd = 1'b1;
            repeat (P) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] c, input logic [7:0] d, input bit bad);
        send_char(c, 1'b0);
        send_char(d, bad);
        repeat (P) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_read(A_CTRL, v); chk("R1", "ctrl reset", v, 32'h0);
        bus_read(A_STAT, v); chk("R1", "stat reset", v, 32'hC0);
        bus_read(A_DATA, v); chk("R1", "data reset", v, 32'h0);
        bus_read(A_BAUD, v); chk("R1", "baud reset", v, 32'h0);
        chk("R1", "txd reset", {31'b0, txd}, 32'h1);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        bus_write(A_CTRL, 32'hA5A5_200C);
        bus_read(A_CTRL, v); chk("R2", "ctrl readback", v, 32'hA5A5_200C);
        bus_write(A_BAUD, 32'hFFFF_1D4C);
        bus_read(A_BAUD, v); chk("R2", "baud low half", v, 32'h0000_1D4C);
        bus_write(A_BAUD, P);
        bus_write(A_CTRL, 32'h0);
    endtask

    task automatic t_tx;
        logic [31:0] v;
        logic [7:0]  b0, b1;
        logic        s0, s1;
        bus_write(A_CTRL, 32'h0000_2008);
        fork
            begin
                capture_byte(b0, s0);
                capture_byte(b1, s1);
            end
            begin
                bus_write(A_DATA, 32'h0000_00A5);
                bus_read(A_STAT, v);
                chk("R3", "shifting flags", v & 32'hC0, 32'h80);
                bus_write(A_DATA, 32'h0000_005A);
                bus_read(A_STAT, v);
                chk("R3", "holding flags", v & 32'hC0, 32'h00);
                // R4: rejected while transmit-empty is 0
                bus_write(A_DATA, 32'h0000_00FF);
            end
        join
        chk("R3", "first byte", {24'b0, b0}, 32'hA5);
        chk("R3", "first stop", {31'b0, s0}, 32'h1);
        chk("R3", "second byte", {24'b0, b1}, 32'h5A);
        chk("R3", "second stop", {31'b0, s1}, 32'h1);
        line_idle("R4", 3 * P);
        bus_read(A_STAT, v);
        chk("R3", "done flags", v & 32'hC0, 32'hC0);
    endtask

    task automatic t_tx_ignored;
        logic [31:0] v;
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); chk("R11", "tc cleared", v, 32'h80);
        bus_write(A_CTRL, 32'h0000_2000);
        bus_write(A_DATA, 32'h0000_000F);
        line_idle("R4", 3 * P);
        bus_read(A_STAT, v); chk("R4", "flags with TE off", v, 32'h80);
        bus_write(A_CTRL, 32'h0000_2008);
        clk_en = 1'b0;
        bus_write(A_DATA, 32'h0000_000F);
        line_idle("R4", 3 * P);
        bus_read(A_STAT, v); chk("R4", "flags with clk_en low", v, 32'h80);
        clk_en = 1'b1;
        line_idle("R4", 3 * P);
    endtask

    task automatic t_rx_basic;
        logic [31:0] v;
        bus_write(A_CTRL, 32'h0000_2004);
        send_frame(8'h12, 8'h34, 1'b0);
        bus_read(A_STAT, v); chk("R5", "frame ready", v & RX_MASK, 32'h21);
        bus_read(A_DATA, v); chk("R5", "packed frame", v, 32'h0000_1234);
        bus_read(A_STAT, v); chk("R6", "read clears", v & RX_MASK, 32'h00);
    endtask

    task automatic t_rx_enable;
        logic [31:0] v;
        bus_write(A_CTRL, 32'h0000_0001);
        send_frame(8'hAB, 8'hCD, 1'b0);
        bus_read(A_STAT, v); chk("R7", "legacy enable", v & RX_MASK, 32'h21);
        bus_read(A_DATA, v); chk("R7", "legacy data", v, 32'h0000_ABCD);
        bus_write(A_CTRL, 32'h0000_2000);
        send_frame(8'h11, 8'h22, 1'b0);
        bus_read(A_STAT, v); chk("R7", "RE off ignored", v & RX_MASK, 32'h00);
        bus_write(A_CTRL, 32'h0000_0004);
        send_frame(8'h33, 8'h44, 1'b0);
        bus_read(A_STAT, v); chk("R7", "UE off ignored", v & RX_MASK, 32'h00);
        bus_read(A_DATA, v); chk("R7", "data kept", v, 32'h0000_ABCD);
    endtask

    task automatic t_rx_gate;
        logic [31:0] v;
        bus_write(A_CTRL, 32'h0000_2004);
        clk_en = 1'b0;
        send_frame(8'h99, 8'h98, 1'b0);
        bus_read(A_STAT, v); chk("R8", "gated no frame", v & RX_MASK, 32'h00);
        clk_en = 1'b1;
        send_frame(8'h55, 8'h66, 1'b0);
        bus_read(A_STAT, v); chk("R8", "ungated frame", v & RX_MASK, 32'h21);
        bus_read(A_DATA, v); chk("R8", "ungated data", v, 32'h0000_5566);
    endtask

    task automatic t_overrun;
        logic [31:0] v;
        send_frame(8'h01, 8'h02, 1'b0);
        send_frame(8'h03, 8'h04, 1'b0);
        bus_read(A_STAT, v); chk("R9", "overrun set", v & RX_MASK, 32'h29);
        bus_read(A_DATA, v); chk("R9", "old frame kept", v, 32'h0000_0102);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_read(A_STAT, v); chk("R11", "ones keep ORE", v & RX_MASK, 32'h08);
        bus_write(A_STAT, 32'h0);
        bus_read(A_STAT, v); chk("R11", "zero clears ORE", v & RX_MASK, 32'h00);
    endtask

    task automatic t_framing;
        logic [31:0] v;
        send_frame(8'h77, 8'h88, 1'b1);
        bus_read(A_STAT, v); chk("R10", "framing flag", v & RX_MASK, 32'h23);
        bus_read(A_DATA, v); chk("R10", "frame delivered", v, 32'h0000_7788);
        bus_write(A_STAT, 32'hFFFF_FFFD);
        bus_read(A_STAT, v); chk("R11", "FE cleared", v & RX_MASK, 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_tx();
        t_tx_ignored();
        t_rx_basic();
        t_rx_enable();
        t_rx_gate();
        t_overrun();
        t_framing();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule